// File: doc/BRIEF.md
# Way-Lockable Cache Allocation Controller

This block owns the tag side of a 4-way set-associative cache in which any way can be locked. A locked way is used as local memory that software manages. Its lines still return hits and can be read or written. Hardware never picks a locked way as a replacement victim, and never fills an empty line in a locked way. The unlocked ways act as a smaller cache that hardware manages. With one, two or three ways locked, that cache has three, two or one ways. With a single unlocked way it is direct-mapped. Each line covers two 32-byte sectors, so the data array beside this block is organised in 64-byte lines.

Each cycle at most one request arrives. A request names an operation, a set and a tag. The operation is a lookup, a fill, a snoop or a write-through conditional store. The block answers in the same cycle. The answer gives the hit and hit way, the way chosen for allocation, an invalidate flag and a bus-forward flag. Valid bits, tags and the replacement order of the addressed set change on the clock edge that ends the request. The lock mask combines two inputs. One is a 4-bit per-way field. The other is a pair of legacy bits, each of which locks two ways together.

Top module: `way_lock_alloc_ctrl`

## Requirements
- R1: A way is locked when its lock bit is set or its pair bit is set. Bit 3 of `lock_way_i` locks way 0, bit 2 locks way 1, bit 1 locks way 2 and bit 0 locks way 3. `lock_pair_lo_i` locks ways 0 and 1, and `lock_pair_hi_i` locks ways 2 and 3.
- R2: For any operation, `rsp_hit_o` is high when a valid line of the addressed set holds the request tag, and `rsp_hit_way_o` gives that way. Hits are returned from locked ways as well as unlocked ways.
- R3: A fill that misses allocates into the lowest-numbered way that is both invalid and unlocked, if such a way exists.
- R4: A fill never allocates into a locked way. This holds even when a locked way is invalid.
- R5: When every unlocked way is valid, a fill replaces the least recently used unlocked way. Lookup hits, hits of write-through stores that keep their line, and allocations all mark a way as most recently used. Hits on locked ways leave the order unchanged.
- R6: When all four ways are locked, a missing fill sets `rsp_miss_pass_o` and leaves `rsp_alloc_o` low. A fill that hits reports the hit and does not allocate.
- R7: When only one way is unlocked, every missing fill allocates into that way.
- R8: A snoop that hits sets `rsp_inval_o` and invalidates the line, in locked and unlocked ways alike. A snoop that misses changes nothing.
- R9: A write-through conditional store (op 3) always sets `rsp_bus_fwd_o`. A hit in a locked way invalidates that line. A hit in an unlocked way keeps the line.
- R10: Op codes are 0 lookup, 1 fill, 2 snoop, 3 write-through store. The response is combinational in the request cycle. The state update is visible to a request in the next cycle.
- R11: Changing the lock inputs neither invalidates nor moves any line.
- R12: After reset, every line is invalid and all response outputs are low while `req_valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_way_i | input | 4 | Per-way lock field, MSB is way 0 |
| lock_pair_lo_i | input | 1 | Locks ways 0 and 1 |
| lock_pair_hi_i | input | 1 | Locks ways 2 and 3 |
| req_valid_i | input | 1 | Request present |
| req_op_i | input | 2 | 0 lookup, 1 fill, 2 snoop, 3 write-through store |
| req_set_i | input | SET_W | Set index |
| req_tag_i | input | TAG_W | Address tag |
| rsp_hit_o | output | 1 | Tag hit in the set |
| rsp_hit_way_o | output | 2 | Hit way |
| rsp_alloc_o | output | 1 | Fill allocates a line |
| rsp_alloc_way_o | output | 2 | Way chosen for allocation |
| rsp_miss_pass_o | output | 1 | Fill missed and no way may be allocated |
| rsp_inval_o | output | 1 | Hit line is invalidated |
| rsp_bus_fwd_o | output | 1 | Store is forwarded to the bus |

## Verification
Wrong internal state shows at the ports one request after it is formed. A valid bit that is not set or not cleared changes the hit result of the next lookup to that set and tag. A corrupted replacement order becomes visible only when a set runs out of invalid unlocked ways. For that reason the tests fill sets completely and then check which way each later fill picks. A lock mask that is merged wrongly shows in the very next fill, as allocation into a way that should be locked.

// File: rtl/wlc_pkg.sv
package wlc_pkg;
  localparam int unsigned WAYS  = 4;
  localparam int unsigned WAY_W = 2;

  typedef enum logic [1:0] {
    OP_LOOKUP   = 2'd0,
    OP_FILL     = 2'd1,
    OP_SNOOP    = 2'd2,
    OP_STORE_WT = 2'd3
  } op_e;

  typedef logic [WAYS-1:0]  way_mask_t;
  typedef logic [WAY_W-1:0] way_idx_t;
  typedef way_idx_t [WAYS-1:0] age_vec_t;
endpackage

// File: rtl/wlc_lock_merge.sv
module wlc_lock_merge
  import wlc_pkg::*;
(
  input  logic [WAYS-1:0] lock_way_i,
  input  logic            pair_lo_i,
  input  logic            pair_hi_i,
  output way_mask_t       lock_eff_o
);
  for (genvar i = 0; i < WAYS; i++) begin : g_way
    if (i < WAYS / 2) begin : g_lo
      assign lock_eff_o[i] = lock_way_i[WAYS-1-i] | pair_lo_i;
    end else begin : g_hi
      assign lock_eff_o[i] = lock_way_i[WAYS-1-i] | pair_hi_i;
    end
  end
endmodule

// File: rtl/wlc_tag_store.sv
module wlc_tag_store
  import wlc_pkg::*;
#(
  parameter int unsigned NUM_SETS = 16,
  parameter int unsigned TAG_W    = 20,
  localparam int unsigned SET_W   = $clog2(NUM_SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] rd_set_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output way_mask_t        valid_o,
  output way_mask_t        hit_vec_o,
  input  logic             wr_en_i,
  input  logic [SET_W-1:0] wr_set_i,
  input  way_idx_t         wr_way_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             inv_en_i,
  input  logic [SET_W-1:0] inv_set_i,
  input  way_idx_t         inv_way_i
);
  way_mask_t        valid_q [NUM_SETS];
  logic [TAG_W-1:0] tag_q   [NUM_SETS][WAYS];

  assign valid_o = valid_q[rd_set_i];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec_o[w] = valid_q[rd_set_i][w] && (tag_q[rd_set_i][w] == rd_tag_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        valid_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
      end
    end else begin
      if (wr_en_i) begin
        valid_q[wr_set_i][wr_way_i] <= 1'b1;
        tag_q[wr_set_i][wr_way_i]   <= wr_tag_i;
      end
      if (inv_en_i) valid_q[inv_set_i][inv_way_i] <= 1'b0;
    end
  end
endmodule

// File: rtl/wlc_lru_store.sv
module wlc_lru_store
  import wlc_pkg::*;
#(
  parameter int unsigned NUM_SETS = 16,
  localparam int unsigned SET_W   = $clog2(NUM_SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] rd_set_i,
  output age_vec_t         age_o,
  input  logic             touch_en_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  way_idx_t         touch_way_i
);
  // age 0 = most recent; ages of a set always form a permutation
  age_vec_t age_q [NUM_SETS];

  assign age_o = age_q[rd_set_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= way_idx_t'(w);
    end else if (touch_en_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (way_idx_t'(w) == touch_way_i)
          age_q[touch_set_i][w] <= '0;
        else if (age_q[touch_set_i][w] < age_q[touch_set_i][touch_way_i])
          age_q[touch_set_i][w] <= age_q[touch_set_i][w] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wlc_victim_pick.sv
module wlc_victim_pick
  import wlc_pkg::*;
(
  input  way_mask_t valid_i,
  input  way_mask_t lock_i,
  input  age_vec_t  age_i,
  output logic      found_o,
  output way_idx_t  way_o
);
  logic     inv_found;
  way_idx_t inv_way;
  logic     lru_found;
  way_idx_t lru_way;
  way_idx_t lru_age;

  always_comb begin
    inv_found = 1'b0;
    inv_way   = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_i[i] && !lock_i[i]) begin
        inv_found = 1'b1;
        inv_way   = way_idx_t'(i);
      end
    end
  end

  always_comb begin
    lru_found = 1'b0;
    lru_way   = '0;
    lru_age   = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!lock_i[i] && (!lru_found || age_i[i] > lru_age)) begin
        lru_found = 1'b1;
        lru_way   = way_idx_t'(i);
        lru_age   = age_i[i];
      end
    end
  end

  assign found_o = lru_found;
  assign way_o   = inv_found ? inv_way : lru_way;
endmodule

// File: rtl/way_lock_alloc_ctrl.sv
module way_lock_alloc_ctrl
  import wlc_pkg::*;
#(
  parameter int unsigned NUM_SETS = 16,
  parameter int unsigned TAG_W    = 20,
  localparam int unsigned SET_W   = $clog2(NUM_SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       lock_way_i,
  input  logic             lock_pair_lo_i,
  input  logic             lock_pair_hi_i,
  input  logic             req_valid_i,
  input  logic [1:0]       req_op_i,
  input  logic [SET_W-1:0] req_set_i,
  input  logic [TAG_W-1:0] req_tag_i,
  output logic             rsp_hit_o,
  output logic [1:0]       rsp_hit_way_o,
  output logic             rsp_alloc_o,
  output logic [1:0]       rsp_alloc_way_o,
  output logic             rsp_miss_pass_o,
  output logic             rsp_inval_o,
  output logic             rsp_bus_fwd_o
);
  op_e       op;
  way_mask_t lock_eff;
  way_mask_t valid_vec;
  way_mask_t hit_vec;
  age_vec_t  age_vec;
  logic      vict_found;
  way_idx_t  vict_way;
  logic      hit_any;
  way_idx_t  hit_way;
  logic      alloc;
  logic      inval;
  logic      touch;

  assign op = op_e'(req_op_i);

  wlc_lock_merge u_lock (
    .lock_way_i (lock_way_i),
    .pair_lo_i  (lock_pair_lo_i),
    .pair_hi_i  (lock_pair_hi_i),
    .lock_eff_o (lock_eff)
  );

  wlc_tag_store #(.NUM_SETS(NUM_SETS), .TAG_W(TAG_W)) u_tags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_set_i  (req_set_i),
    .rd_tag_i  (req_tag_i),
    .valid_o   (valid_vec),
    .hit_vec_o (hit_vec),
    .wr_en_i   (alloc),
    .wr_set_i  (req_set_i),
    .wr_way_i  (vict_way),
    .wr_tag_i  (req_tag_i),
    .inv_en_i  (inval),
    .inv_set_i (req_set_i),
    .inv_way_i (hit_way)
  );

  wlc_lru_store #(.NUM_SETS(NUM_SETS)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_set_i    (req_set_i),
    .age_o       (age_vec),
    .touch_en_i  (touch),
    .touch_set_i (req_set_i),
    .touch_way_i (alloc ? vict_way : hit_way)
  );

  wlc_victim_pick u_vict (
    .valid_i (valid_vec),
    .lock_i  (lock_eff),
    .age_i   (age_vec),
    .found_o (vict_found),
    .way_o   (vict_way)
  );

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) if (hit_vec[w]) hit_way = way_idx_t'(w);
  end
  assign hit_any = |hit_vec;

  assign alloc = req_valid_i && (op == OP_FILL) && !hit_any && vict_found;

  always_comb begin
    inval = 1'b0;
    if (req_valid_i && hit_any) begin
      unique case (op)
        OP_SNOOP:    inval = 1'b1;
        OP_STORE_WT: inval = lock_eff[hit_way];
        default:     inval = 1'b0;
      endcase
    end
  end

  // locked ways are kept out of the replacement order
  assign touch = alloc ||
                 (req_valid_i && hit_any && !lock_eff[hit_way] && (op != OP_SNOOP));

  assign rsp_hit_o       = req_valid_i && hit_any;
  assign rsp_hit_way_o   = hit_way;
  assign rsp_alloc_o     = alloc;
  assign rsp_alloc_way_o = vict_way;
  assign rsp_miss_pass_o = req_valid_i && (op == OP_FILL) && !hit_any && !vict_found;
  assign rsp_inval_o     = inval;
  assign rsp_bus_fwd_o   = req_valid_i && (op == OP_STORE_WT);
endmodule

module wlc_checker #(
  parameter int unsigned SET_W = 4,
  parameter int unsigned TAG_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       lock_way_i,
  input logic             lock_pair_lo_i,
  input logic             lock_pair_hi_i,
  input logic             req_valid_i,
  input logic [1:0]       req_op_i,
  input logic [SET_W-1:0] req_set_i,
  input logic [TAG_W-1:0] req_tag_i,
  input logic             rsp_hit_o,
  input logic [1:0]       rsp_hit_way_o,
  input logic             rsp_alloc_o,
  input logic [1:0]       rsp_alloc_way_o,
  input logic             rsp_miss_pass_o,
  input logic             rsp_inval_o,
  input logic [3:0]       hit_vec_i
);
  logic [3:0] lk;
  always_comb
    for (int i = 0; i < 4; i++)
      lk[i] = lock_way_i[3-i] | (i < 2 ? lock_pair_lo_i : lock_pair_hi_i);

  // R4
  alloc_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_alloc_o |-> !lk[rsp_alloc_way_o]);

  // R6
  all_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'd1 && (&lk)) |-> !rsp_alloc_o);

  // R2
  single_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec_i));

  // R8
  inval_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_inval_o |-> rsp_hit_o);

  // R6
  alloc_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_alloc_o && (rsp_hit_o || rsp_miss_pass_o)));

  // R10
  fill_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_alloc_o ##1 (req_valid_i && req_op_i == 2'd0 &&
                     req_set_i == $past(req_set_i) && req_tag_i == $past(req_tag_i))
    |-> (rsp_hit_o && rsp_hit_way_o == $past(rsp_alloc_way_o)));
endmodule

bind way_lock_alloc_ctrl wlc_checker #(.SET_W(SET_W), .TAG_W(TAG_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .lock_way_i      (lock_way_i),
  .lock_pair_lo_i  (lock_pair_lo_i),
  .lock_pair_hi_i  (lock_pair_hi_i),
  .req_valid_i     (req_valid_i),
  .req_op_i        (req_op_i),
  .req_set_i       (req_set_i),
  .req_tag_i       (req_tag_i),
  .rsp_hit_o       (rsp_hit_o),
  .rsp_hit_way_o   (rsp_hit_way_o),
  .rsp_alloc_o     (rsp_alloc_o),
  .rsp_alloc_way_o (rsp_alloc_way_o),
  .rsp_miss_pass_o (rsp_miss_pass_o),
  .rsp_inval_o     (rsp_inval_o),
  .hit_vec_i       (hit_vec)
);

// File: tb/tb_way_lock_alloc_ctrl.sv
module tb_way_lock_alloc_ctrl;
  localparam int SET_W = 4;
  localparam int TAG_W = 20;
  localparam logic [1:0] LK = 2'd0, FL = 2'd1, SN = 2'd2, ST = 2'd3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [3:0]       lock_way = '0;
  logic             pair_lo = 1'b0, pair_hi = 1'b0;
  logic             req_valid = 1'b0;
  logic [1:0]       req_op = '0;
  logic [SET_W-1:0] req_set = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic             hit, alloc, miss_pass, inval, bus_fwd;
  logic [1:0]       hit_way, alloc_way;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  way_lock_alloc_ctrl #(.NUM_SETS(16), .TAG_W(TAG_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .lock_way_i(lock_way),
    .lock_pair_lo_i(pair_lo), .lock_pair_hi_i(pair_hi),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_set_i(req_set), .req_tag_i(req_tag),
    .rsp_hit_o(hit), .rsp_hit_way_o(hit_way), .rsp_alloc_o(alloc),
    .rsp_alloc_way_o(alloc_way), .rsp_miss_pass_o(miss_pass),
    .rsp_inval_o(inval), .rsp_bus_fwd_o(bus_fwd)
  );

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // drive at negedge, sample before the posedge, request ends on that posedge
  task automatic rq(logic [1:0] op, int set, int tag);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_set = SET_W'(set); req_tag = TAG_W'(tag);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic fill_exp(string r, int set, int tag, int way);
    rq(FL, set, tag);
    chk({r, " alloc"}, alloc, 1);
    chk({r, " way"}, alloc_way, way);
  endtask

  task automatic look_exp(string r, int set, int tag, int h, int way);
    rq(LK, set, tag);
    chk({r, " hit"}, hit, h);
    if (h) chk({r, " hit_way"}, hit_way, way);
  endtask

  task automatic t_reset();
    #1;
    chk("R12 idle hit", hit, 0);
    chk("R12 idle alloc", alloc, 0);
    chk("R12 idle fwd", bus_fwd, 0);
    look_exp("R12 empty", 7, 'h0, 0, 0);
    idle();
  endtask

  task automatic t_unlocked_lru();
    lock_way = 4'b0000; pair_lo = 0; pair_hi = 0;
    for (int i = 0; i < 4; i++) fill_exp("R3 set0", 0, 'h100 + i, i);
    look_exp("R10 fill visible", 0, 'h103, 1, 3);
    fill_exp("R5 lru evict", 0, 'h104, 0);
    look_exp("R2 touch", 0, 'h101, 1, 1);
    fill_exp("R5 after touch", 0, 'h105, 2);
    look_exp("R5 evicted gone", 0, 'h100, 0, 0);
    rq(FL, 0, 'h104);
    chk("R6 fill hit no alloc", alloc, 0);
    chk("R6 fill hit", hit, 1);
    idle();
  endtask

  task automatic t_lock_way0();
    lock_way = 4'b1000;
    fill_exp("R4 skip locked invalid", 1, 'h200, 1);
    fill_exp("R3 next", 1, 'h201, 2);
    fill_exp("R3 next2", 1, 'h202, 3);
    fill_exp("R5 lru among unlocked", 1, 'h203, 1);
    look_exp("R4 way0 empty", 1, 'h200, 0, 0);
    idle();
  endtask

  task automatic t_pair_locks();
    lock_way = 4'b0000; pair_lo = 1;
    fill_exp("R1 lo pair", 2, 'h300, 2);
    fill_exp("R1 lo pair b", 2, 'h301, 3);
    fill_exp("R5 lo pair lru", 2, 'h302, 2);
    pair_lo = 0; pair_hi = 1;
    fill_exp("R1 hi pair", 4, 'h400, 0);
    pair_hi = 0;
    idle();
  endtask

  task automatic t_direct_map();
    lock_way = 4'b0100; pair_hi = 1;  // only way 0 unlocked
    fill_exp("R7 dm a", 5, 'h500, 0);
    fill_exp("R7 dm b", 5, 'h501, 0);
    look_exp("R7 dm replaced", 5, 'h500, 0, 0);
    pair_hi = 0; lock_way = 4'b1110;  // only way 3 unlocked
    fill_exp("R7 dm way3", 5, 'h502, 3);
    fill_exp("R7 dm way3 b", 5, 'h503, 3);
    look_exp("R11 way0 kept", 5, 'h501, 1, 0);
    idle();
  endtask

  task automatic t_all_locked();
    lock_way = 4'b1111;
    rq(FL, 6, 'h600);
    chk("R6 no alloc", alloc, 0);
    chk("R6 miss pass", miss_pass, 1);
    look_exp("R6 nothing filled", 6, 'h600, 0, 0);
    look_exp("R2 locked hit", 0, 'h103, 1, 3);
    lock_way = 4'b0000;
    look_exp("R11 unlock keeps", 0, 'h105, 1, 2);
    idle();
  endtask

  task automatic t_snoop();
    lock_way = 4'b1111;
    rq(SN, 0, 'h103);
    chk("R8 snoop locked hit inval", inval, 1);
    look_exp("R8 line gone", 0, 'h103, 0, 0);
    rq(SN, 0, 'h999);
    chk("R8 snoop miss inval", inval, 0);
    look_exp("R8 other line kept", 0, 'h104, 1, 0);
    idle();
  endtask

  task automatic t_store_wt();
    lock_way = 4'b0100;  // way 1 locked
    rq(ST, 0, 'h101);
    chk("R9 locked hit", hit, 1);
    chk("R9 locked inval", inval, 1);
    chk("R9 locked fwd", bus_fwd, 1);
    look_exp("R9 locked line gone", 0, 'h101, 0, 0);
    rq(ST, 0, 'h105);
    chk("R9 unlocked inval", inval, 0);
    chk("R9 unlocked fwd", bus_fwd, 1);
    look_exp("R9 unlocked kept", 0, 'h105, 1, 2);
    rq(ST, 0, 'h777);
    chk("R9 miss fwd", bus_fwd, 1);
    chk("R9 miss hit", hit, 0);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unlocked_lru();
    t_lock_way0();
    t_pair_locks();
    t_direct_map();
    t_all_locked();
    t_snoop();
    t_store_wt();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule